// File: doc/BRIEF.md
# Token-Holding Client Access Controller

This block is the per-client half of a token-passing bus access scheme. Each client that wants the shared bus has one of these controllers. A central selector points at one controller at a time. The controller answers that pointer in one of two ways. If its client is requesting, it keeps the token and acknowledges the client. If the client is not requesting, it hands the token on with a one-cycle `pass_ctrl` pulse. The selector uses that pulse to move its pointer to the next controller.

Once it holds the token, the controller keeps `ack` high for as long as the client keeps `req` high, so each service can last a different number of cycles. When `req` falls, the controller drops `ack` and pulses `pass_ctrl`. All outputs come from registers and change on the clock edge after the inputs that cause them. In the cycle a controller passes the token on, it ignores `selected`. The selector therefore has one cycle to move its pointer before it can take the token back.

Top module: `token_access_ctl`

## Requirements
- R1: Synchronous reset (`rst` high at a rising edge) leaves `ack` and `pass_ctrl` both low on the following cycle.
- R2: When `ack`, `pass_ctrl` and the other idle conditions hold, and `selected` and `req` are both high at a rising edge, `ack` is high from the next cycle. Idle means `ack` low and `pass_ctrl` low.
- R3: When the controller is idle and `selected` is low at a rising edge, `ack` and `pass_ctrl` are both low in the next cycle, whatever the value of `req`.
- R4: While `ack` is high and `req` stays high at a rising edge, `ack` stays high in the next cycle, whatever the value of `selected`.
- R5: When `ack` is high and `req` is low at a rising edge, the next cycle has `ack` low and `pass_ctrl` high.
- R6: When the controller is idle, `selected` is high and `req` is low at a rising edge, the next cycle has `pass_ctrl` high and `ack` low.
- R7: `pass_ctrl` is never high in two consecutive cycles, and `ack` and `pass_ctrl` are never high together.
- R8: In a cycle where `pass_ctrl` is high, both `selected` and `req` are ignored: the next cycle has `ack` and `pass_ctrl` both low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Client request for the bus |
| selected | input | 1 | Selector is currently pointing at this controller |
| ack | output | 1 | Client holds the bus (token held) |
| pass_ctrl | output | 1 | One-cycle pulse handing the token to the next controller |

## Verification
Every result is due exactly one rising edge after the inputs that cause it: `ack` and `pass_ctrl` both come straight from flops, with no combinational path from input to output. The bench drives `req` and `selected` on the falling edge. It advances its own reference state at the next rising edge, then compares both outputs on the following falling edge, half a period after the flops update. Each comparison is tagged with the requirement that governs the transition the reference just made. The exclusivity rule of R7 is checked in every cycle.

// File: rtl/tac_pkg.sv
package tac_pkg;

  typedef enum logic [0:0] {
    TAC_IDLE = 1'b0,
    TAC_HOLD = 1'b1
  } tac_state_e;

  // Token may be taken: selector points here, client asks, not mid hand-off.
  function automatic logic tac_grab(input logic sel, input logic rq, input logic passing);
    return sel & rq & ~passing;
  endfunction

  // Token must be declined: selector points here but client is silent.
  function automatic logic tac_decline(input logic sel, input logic rq, input logic passing);
    return sel & ~rq & ~passing;
  endfunction

  // Service ends when the client withdraws its request.
  function automatic logic tac_finish(input logic rq);
    return ~rq;
  endfunction

endpackage

// File: rtl/tac_decide.sv
module tac_decide
  import tac_pkg::*;
(
  input  tac_state_e state_q,
  input  logic       pass_q,
  input  logic       req,
  input  logic       selected,
  output tac_state_e state_d,
  output logic       pass_d,
  output logic       take_ev,
  output logic       decline_ev,
  output logic       finish_ev
);

  logic in_idle;
  logic in_hold;

  assign in_idle = (state_q == TAC_IDLE);
  assign in_hold = (state_q == TAC_HOLD);

  assign take_ev    = in_idle & tac_grab(selected, req, pass_q);
  assign decline_ev = in_idle & tac_decline(selected, req, pass_q);
  assign finish_ev  = in_hold & tac_finish(req);

  always_comb begin
    state_d = state_q;
    if (take_ev) begin
      state_d = TAC_HOLD;
    end else if (finish_ev) begin
      state_d = TAC_IDLE;
    end
  end

  assign pass_d = decline_ev | finish_ev;

endmodule

// File: rtl/tac_regs.sv
module tac_regs
  import tac_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  tac_state_e state_d,
  input  logic       pass_d,
  output tac_state_e state_q,
  output logic       pass_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= TAC_IDLE;
      pass_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pass_q  <= pass_d;
    end
  end

endmodule

// File: rtl/token_access_ctl.sv
module token_access_ctl
  import tac_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic selected,
  output logic ack,
  output logic pass_ctrl
);

  tac_state_e state_q;
  tac_state_e state_d;
  logic       pass_q;
  logic       pass_d;
  logic       take_ev;
  logic       decline_ev;
  logic       finish_ev;

  tac_decide decide_i (
    .state_q    (state_q),
    .pass_q     (pass_q),
    .req        (req),
    .selected   (selected),
    .state_d    (state_d),
    .pass_d     (pass_d),
    .take_ev    (take_ev),
    .decline_ev (decline_ev),
    .finish_ev  (finish_ev)
  );

  tac_regs regs_i (
    .clk     (clk),
    .rst     (rst),
    .state_d (state_d),
    .pass_d  (pass_d),
    .state_q (state_q),
    .pass_q  (pass_q)
  );

  assign ack       = (state_q == TAC_HOLD);
  assign pass_ctrl = pass_q;

endmodule

// File: rtl/token_access_ctl_chk.sv
module token_access_ctl_chk (
  input logic clk,
  input logic rst,
  input logic req,
  input logic selected,
  input logic ack,
  input logic pass_ctrl,
  input logic take_ev,
  input logic decline_ev,
  input logic finish_ev
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> (!ack && !pass_ctrl));

  // R2
  grab_acks_chk: assert property (@(posedge clk) disable iff (rst)
    (!ack && !pass_ctrl && selected && req) |=> ack);

  // R3
  unselected_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!ack && !pass_ctrl && !selected) |=> (!ack && !pass_ctrl));

  // R4
  hold_while_req_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && req) |=> ack);

  // R5
  finish_passes_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && !req) |=> (!ack && pass_ctrl));

  // R6
  decline_passes_chk: assert property (@(posedge clk) disable iff (rst)
    (!ack && !pass_ctrl && selected && !req) |=> (pass_ctrl && !ack));

  // R7
  pass_single_chk: assert property (@(posedge clk) disable iff (rst)
    pass_ctrl |=> !pass_ctrl);

  // R7
  pass_ack_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(pass_ctrl && ack));

  // R8
  no_regrab_chk: assert property (@(posedge clk) disable iff (rst)
    pass_ctrl |=> (!ack && !pass_ctrl));

  // R7
  events_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({take_ev, decline_ev, finish_ev}));

endmodule

bind token_access_ctl token_access_ctl_chk chk_i (
  .clk        (clk),
  .rst        (rst),
  .req        (req),
  .selected   (selected),
  .ack        (ack),
  .pass_ctrl  (pass_ctrl),
  .take_ev    (take_ev),
  .decline_ev (decline_ev),
  .finish_ev  (finish_ev)
);

// File: tb/token_access_ctl_tb_top.sv
`timescale 1ns/1ps
module token_access_ctl_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0;
  logic selected = 1'b0;
  logic ack;
  logic pass_ctrl;

  int checks = 0;
  int fails  = 0;
  logic m_ack  = 1'b0;
  logic m_pass = 1'b0;
  string m_tag = "R1";

  always #4 clk = ~clk;

  token_access_ctl dut_i (
    .clk       (clk),
    .rst       (rst),
    .req       (req),
    .selected  (selected),
    .ack       (ack),
    .pass_ctrl (pass_ctrl)
  );

  // Reference next state {ack, pass} from the requirements.
  function automatic logic [1:0] ref_next(input logic a, input logic p,
                                          input logic r, input logic s, input logic x);
    if (x)      return 2'b00;       // R1
    if (a)      return r ? 2'b10 : 2'b01; // R4 / R5
    if (p)      return 2'b00;       // R8
    if (!s)     return 2'b00;       // R3
    return r ? 2'b10 : 2'b01;       // R2 / R6
  endfunction

  function automatic string ref_tag(input logic a, input logic p,
                                    input logic r, input logic s, input logic x);
    if (x)  return "R1";
    if (a)  return r ? "R4" : "R5";
    if (p)  return "R8";
    if (!s) return "R3";
    return r ? "R2" : "R6";
  endfunction

  task automatic check_bit(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Drive at falling edge, advance reference at rising edge, compare at next falling edge.
  task automatic step(input logic r, input logic s, input logic x);
    logic [1:0] nx;
    req = r;
    selected = s;
    rst = x;
    @(posedge clk);
    nx = ref_next(m_ack, m_pass, r, s, x);
    m_tag = ref_tag(m_ack, m_pass, r, s, x);
    m_ack = nx[1];
    m_pass = nx[0];
    @(negedge clk);
    check_bit(m_tag, "ack", ack, m_ack);
    check_bit(m_tag, "pass_ctrl", pass_ctrl, m_pass);
    check_bit("R7", "ack&pass_ctrl", ack & pass_ctrl, 1'b0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog expired at %0t", $time);
    finish_run();
  end

  initial begin
    logic r;
    logic s;
    int seed;
    seed = 32'h5eed;
    r = $urandom(seed);
    @(negedge clk);
    // R1: reset state
    step(1'b1, 1'b1, 1'b1);
    step(1'b0, 1'b0, 1'b1);
    // R3: request without selection never acks
    step(1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0);
    // R2: grab
    step(1'b1, 1'b1, 1'b0);
    // R4: hold while selection moves away
    step(1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b1, 1'b0);
    step(1'b1, 1'b0, 1'b0);
    // R5: finish
    step(1'b0, 1'b0, 1'b0);
    // R8: selected with request during the pass pulse is ignored
    step(1'b1, 1'b1, 1'b0);
    step(1'b1, 1'b1, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    // R6: decline, then R8 with selection held
    step(1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    // reset while holding (R1)
    step(1'b1, 1'b1, 1'b0);
    step(1'b1, 1'b1, 1'b1);
    step(1'b0, 1'b0, 1'b0);
    // Constrained random: client keeps req until ack, then holds a while.
    r = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      logic x;
      if (m_ack) r = ($urandom % 4) != 0;
      else if (!r) r = ($urandom % 3) == 0;
      s = ($urandom % 2) == 1;
      x = ($urandom % 200) == 0;
      step(r, s, x);
      if (x) r = 1'b0;
    end
    finish_run();
  end

endmodule